// File: doc/BRIEF.md
# General-Purpose Event Status Controller

This block collects wake and notification events into one status register and raises a single system interrupt while any enabled event is flagged. The lower part of the event space belongs to fixed platform sources, such as a critically low battery, a hotplug request, or a device wake (PME) line. The upper part is fed one-to-one by general-purpose input lines, offset by the number of fixed sources. Software reads the status register to find the source, clears it by writing ones, and enables events and selects their trigger type through four registers.

Each input passes through a two-stage synchroniser. A general-purpose input then passes through a per-line polarity inversion. Each event is captured either as a level or as an edge. A level event keeps setting its status bit while its qualified input stays active. This fits a PME line that the device holds until the wake is acknowledged. Firmware can quiet a level event on a switch input by inverting that line's polarity. The next event then comes on the opposite transition of the switch.

Top module: `gpe_status_ctrl`

## Requirements
- R1: After reset the status, enable, polarity and trigger registers all read 0, and `irq_o` is 0.
- R2: Fixed input k sets status bit k. General-purpose input n sets status bit n+NUM_FIXED, which is bit n+16 with the default parameters.
- R3: A change on any event input that is present before clock edge e reaches the status register at edge e+2 and no earlier. That is two synchroniser stages plus the capture register.
- R4: The qualified form of general-purpose input n is the input XOR polarity bit n+NUM_FIXED, where 1 means active-low. Polarity bits below NUM_FIXED cannot be written and always read 0.
- R5: An event whose trigger bit is 1 (level) sets its status bit on every clock while its qualified input is active. After a clear it therefore reads 1 again one clock later.
- R6: An event whose trigger bit is 0 (edge) sets its status bit only on an inactive-to-active change of its qualified input. Holding the input active after a clear leaves the bit at 0. A polarity flip that makes the qualified input active counts as such a change.
- R7: A write to the status register clears each bit written as 1 and leaves each bit written as 0 untouched. A clear takes priority over a set in the same clock. Status bits never drop without a clear.
- R8: `irq_o` is 1 exactly when, one clock earlier, some status bit and its enable bit were both 1.
- R9: Register selection by `reg_addr_i` is 0 = status (write 1 to clear), 1 = enable, 2 = polarity, 3 = trigger type. Writes take effect at the clock edge where `reg_wr_i` is 1, and `reg_rdata_o` reflects the selected register without a clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_evt_i | input | NUM_FIXED | Fixed platform event sources, active high |
| gpio_i | input | NUM_GPIO | General-purpose input lines |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | NUM_FIXED+NUM_GPIO | Write data |
| reg_rdata_o | output | NUM_FIXED+NUM_GPIO | Read data of selected register |
| irq_o | output | 1 | Registered system interrupt |

## Verification
The bench builds the block with four fixed sources and four general-purpose lines, so the event register is eight bits wide. With that size, every event can be walked one at a time through the pipeline for mapping and latency. Every pairing of the sixteen polarity settings with the sixteen input patterns is swept in level mode, with the result predicted as an XOR. The small width also keeps edge capture, polarity-flip events, clear priority and interrupt gating short enough to check bit by bit.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
    localparam int unsigned GPE_SEL_W = 2;

    typedef enum logic [GPE_SEL_W-1:0] {
        SEL_STATUS   = 2'd0,
        SEL_ENABLE   = 2'd1,
        SEL_POLARITY = 2'd2,
        SEL_TRIGGER  = 2'd3
    } gpe_sel_e;
endpackage

// File: rtl/gpe_sync.sv
// Two-stage synchroniser for a vector of asynchronous event inputs.
module gpe_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpe_capture.sv
// Applies polarity, then produces per-event set pulses by level or by edge.
module gpe_capture #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] invert_i,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] set_o
);
    logic [W-1:0] active;
    logic [W-1:0] prev_d, prev_q;

    assign active = evt_i ^ invert_i;

    always_comb begin
        prev_d = active;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign set_o[i] = level_i[i] ? active[i] : (active[i] & ~prev_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/gpe_status_ctrl.sv
module gpe_status_ctrl #(
    parameter int unsigned NUM_FIXED = 16,
    parameter int unsigned NUM_GPIO  = 16,
    localparam int unsigned EVT_W    = NUM_FIXED + NUM_GPIO
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FIXED-1:0] fixed_evt_i,
    input  logic [NUM_GPIO-1:0]  gpio_i,
    input  logic [1:0]           reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [EVT_W-1:0]     reg_wdata_i,
    output logic [EVT_W-1:0]     reg_rdata_o,
    output logic                 irq_o
);
    import gpe_pkg::*;

    localparam logic [EVT_W-1:0] POL_MASK = {{NUM_GPIO{1'b1}}, {NUM_FIXED{1'b0}}};

    typedef struct packed {
        logic [EVT_W-1:0] status;
        logic [EVT_W-1:0] enable;
        logic [EVT_W-1:0] polarity;
        logic [EVT_W-1:0] trigger;
        logic             irq;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [EVT_W-1:0] raw_evt;
    logic [EVT_W-1:0] sync_evt;
    logic [EVT_W-1:0] set_evt;
    logic [EVT_W-1:0] clr_evt;
    gpe_sel_e         sel;

    assign raw_evt = {gpio_i, fixed_evt_i};
    assign sel     = gpe_sel_e'(reg_addr_i);

    gpe_sync #(.W(EVT_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_evt),
        .sync_o  (sync_evt)
    );

    gpe_capture #(.W(EVT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (sync_evt),
        .invert_i (st_q.polarity),
        .level_i  (st_q.trigger),
        .set_o    (set_evt)
    );

    always_comb begin
        st_d    = st_q;
        clr_evt = (reg_wr_i && sel == SEL_STATUS) ? reg_wdata_i : '0;

        // clear wins over a simultaneous set; level events return next clock
        st_d.status = (st_q.status | set_evt) & ~clr_evt;

        if (reg_wr_i) begin
            unique case (sel)
                SEL_ENABLE:   st_d.enable   = reg_wdata_i;
                SEL_POLARITY: st_d.polarity = reg_wdata_i & POL_MASK;
                SEL_TRIGGER:  st_d.trigger  = reg_wdata_i;
                default:      ;
            endcase
        end

        st_d.irq = |(st_q.status & st_q.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS:   reg_rdata_o = st_q.status;
            SEL_ENABLE:   reg_rdata_o = st_q.enable;
            SEL_POLARITY: reg_rdata_o = st_q.polarity;
            default:      reg_rdata_o = st_q.trigger;
        endcase
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/gpe_status_chk.sv
module gpe_status_chk #(
    parameter int unsigned EVT_W     = 32,
    parameter int unsigned NUM_FIXED = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       reg_addr,
    input logic             reg_wr,
    input logic [EVT_W-1:0] reg_wdata,
    input logic [EVT_W-1:0] status,
    input logic [EVT_W-1:0] enable,
    input logic [EVT_W-1:0] polarity,
    input logic             irq
);
    logic [EVT_W-1:0] wr_clear;
    assign wr_clear = (reg_wr && reg_addr == 2'd0) ? reg_wdata : '0;

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> ((status & $past(reg_wdata)) == '0));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status & ~$past(wr_clear)) == '0));

    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(status & enable)));

    a_r4_fixed_pol_zero: assert property (@(posedge clk) disable iff (!rst_n)
        polarity[NUM_FIXED-1:0] == '0);

    a_r9_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> (enable == $past(reg_wdata)));
endmodule

bind gpe_status_ctrl gpe_status_chk #(.EVT_W(EVT_W), .NUM_FIXED(NUM_FIXED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr_i),
    .reg_wr    (reg_wr_i),
    .reg_wdata (reg_wdata_i),
    .status    (st_q.status),
    .enable    (st_q.enable),
    .polarity  (st_q.polarity),
    .irq       (irq_o)
);

// File: tb/tb_gpe_status_ctrl.sv
`timescale 1ns/1ps
module tb_gpe_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 4;
    localparam int NG = 4;
    localparam int EW = NF + NG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] fixed_evt = '0;
    logic [NG-1:0] gpio = '0;
    logic [1:0]    addr = 2'd0;
    logic          wr = 1'b0;
    logic [EW-1:0] wdata = '0;
    logic [EW-1:0] rdata;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpe_status_ctrl #(.NUM_FIXED(NF), .NUM_GPIO(NG)) dut (
        .clk(clk), .rst_n(rst_n), .fixed_evt_i(fixed_evt), .gpio_i(gpio),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [EW-1:0] got, input logic [EW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [EW-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [EW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic set_inputs(input logic [EW-1:0] v);
        fixed_evt = v[NF-1:0];
        gpio      = v[EW-1:NF];
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [EW-1:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset values
        for (int a = 0; a < 4; a++) begin
            reg_read(a[1:0], v);
            check($sformatf("R1 reg %0d", a), v, '0);
        end
        check("R1 irq", {7'd0, irq}, '0);

        // R2 R3 R5: each event walked alone in level mode
        reg_write(2'd3, '1);
        for (int i = 0; i < EW; i++) begin
            set_inputs(EW'(1) << i);
            tick(2);
            reg_read(2'd0, v);
            check($sformatf("R3 early bit %0d", i), v, '0);
            tick(1);
            reg_read(2'd0, v);
            check($sformatf("R2 bit %0d", i), v, EW'(1) << i);
            set_inputs('0);
            tick(3);
            reg_write(2'd0, '1);
            reg_read(2'd0, v);
            check($sformatf("R7 cleared %0d", i), v, '0);
        end

        // R4 R5 R7: all polarity settings against all gpio patterns, level mode
        for (int p = 0; p < 16; p++) begin
            reg_write(2'd2, {p[3:0], 4'hF});
            reg_read(2'd2, v);
            check($sformatf("R4 readback pol %0d", p), v, {p[3:0], 4'h0});
            for (int g = 0; g < 16; g++) begin
                gpio = g[3:0];
                tick(3);
                reg_write(2'd0, '1);
                reg_read(2'd0, v);
                check($sformatf("R7 clear priority p%0d g%0d", p, g), v, '0);
                tick(1);
                reg_read(2'd0, v);
                check($sformatf("R4 R5 p%0d g%0d", p, g), v, {g[3:0] ^ p[3:0], 4'h0});
            end
        end
        gpio = '0;
        reg_write(2'd2, '0);
        tick(3);
        reg_write(2'd0, '1);

        // R6: edge mode on fixed source 1 held high
        reg_write(2'd3, '0);
        fixed_evt = 4'b0010;
        tick(3);
        reg_read(2'd0, v);
        check("R6 edge set", v, 8'h02);
        reg_write(2'd0, 8'h02);
        tick(3);
        reg_read(2'd0, v);
        check("R6 held no reset", v, '0);
        fixed_evt = '0;
        tick(3);
        fixed_evt = 4'b0010;
        tick(3);
        reg_read(2'd0, v);
        check("R6 second edge", v, 8'h02);
        fixed_evt = '0;
        reg_write(2'd0, '1);

        // R6: polarity flip on idle gpio 2 yields an edge
        tick(3);
        reg_write(2'd2, 8'h40);
        tick(1);
        reg_read(2'd0, v);
        check("R6 polarity flip edge", v, 8'h40);
        reg_write(2'd2, 8'h00);
        reg_write(2'd0, '1);
        tick(2);
        reg_read(2'd0, v);
        check("R6 flip back quiet", v, '0);

        // R7: write 0 leaves other bits
        fixed_evt = 4'b0101;
        tick(3);
        fixed_evt = '0;
        reg_write(2'd0, 8'h01);
        reg_read(2'd0, v);
        check("R7 partial clear", v, 8'h04);

        // R8 R9: interrupt gating by enable
        reg_write(2'd1, 8'h08);
        reg_read(2'd1, v);
        check("R9 enable readback", v, 8'h08);
        tick(2);
        check("R8 masked irq", {7'd0, irq}, '0);
        reg_write(2'd1, 8'h04);
        check("R8 irq not yet", {7'd0, irq}, '0);
        tick(1);
        check("R8 irq high", {7'd0, irq}, 8'h01);
        reg_write(2'd0, 8'h04);
        check("R8 irq still high", {7'd0, irq}, 8'h01);
        tick(1);
        check("R8 irq low", {7'd0, irq}, '0);

        // R9: trigger register readback
        reg_write(2'd3, 8'hA5);
        reg_read(2'd3, v);
        check("R9 trigger readback", v, 8'hA5);

        done = 1'b1;
        report();
        $finish;
    end
endmodule